// File: doc/BRIEF.md
# Debug Receive Mailbox with Overflow Detection

This block holds one data word passed from an external debugger port to an on-chip debug handler. The debugger side presents a parallel write strobe with a data word, a valid bit and a download bit. The handler side polls a status word, reads the held word and can write a control word. Three flags live in the status word: receive-ready, a sticky overflow and download mode.

In ordinary transfers the debugger waits for receive-ready to drop before it writes again. In fast download mode the debugger writes back to back without waiting. If the handler falls behind, the block records the loss in the sticky overflow flag and does not stall the writer. The download flag replaces a handler loop counter. The handler keeps looping while it reads set. The debugger clears it with a separate strobe when the transfer is over.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: A synchronous active-high reset clears the held word, receive-ready, overflow and download, so the status word reads zero.
- R2: A write strobe with the valid bit high loads the word and sets receive-ready at that edge. A strobe with the valid bit low changes nothing.
- R3: A valid write with the download bit high sets download at the same edge. A valid write with the download bit low leaves download as it was.
- R4: A valid write that arrives while receive-ready is set, with no handler read in the same cycle, sets overflow. The new word replaces the held one and receive-ready stays set.
- R5: Overflow is sticky through later writes, reads and download changes. Only a control write with bit 30 low clears it. A control write with bit 30 high leaves it set. If an overflowing write falls in the same cycle as a clearing control write, overflow ends set.
- R6: A handler read clears receive-ready at the next edge and leaves the held word unchanged.
- R7: When a handler read and a valid write fall in the same cycle, the write wins. Receive-ready stays set, the new word is held, and overflow is not set by that write.
- R8: The clear-download strobe clears download and leaves the held word and receive-ready unchanged. If it falls in the same cycle as a valid write with the download bit high, download ends set.
- R9: The status word carries receive-ready at bit 31, overflow at bit 30 and download at bit 29. All other bits read zero.
- R10: A control write never changes receive-ready, download or the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_valid | input | 1 | Valid bit of the debugger write |
| dbg_dl | input | 1 | Download bit of the debugger write |
| dbg_wdata | input | DATA_W | Word written by the debugger |
| dbg_dl_clr | input | 1 | Debugger strobe that ends download mode |
| hnd_rd | input | 1 | Handler read of the held word |
| hnd_rdata | output | DATA_W | Held word |
| hnd_ctl_wr | input | 1 | Handler control write strobe |
| hnd_ctl_wdata | input | DATA_W | Control write value; bit 30 low clears overflow |
| hnd_status | output | DATA_W | Status word: receive-ready, overflow, download |

## Verification
The bench targets the cycle collisions. The first is a read and a write in the same cycle: a design where the read won would drop receive-ready with fresh data held, and a design that ignored the read would raise a false overflow. The second is an overflowing write coinciding with an overflow clear: a design that let the clear win would hide a lost word. The third is a clear-download strobe coinciding with a download write. The bench also drives control writes with bit 30 high, invalid strobes and reads with nothing held, which a design that acted on them would turn into flag or data changes visible in the status word.

// File: rtl/dbg_rx_mailbox.sv
module dbg_rx_mailbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_wr,
  input  logic              dbg_valid,
  input  logic              dbg_dl,
  input  logic [DATA_W-1:0] dbg_wdata,
  input  logic              dbg_dl_clr,
  input  logic              hnd_rd,
  output logic [DATA_W-1:0] hnd_rdata,
  input  logic              hnd_ctl_wr,
  input  logic [DATA_W-1:0] hnd_ctl_wdata,
  output logic [DATA_W-1:0] hnd_status
);
  localparam int RR_BIT = DATA_W - 1;
  localparam int OV_BIT = DATA_W - 2;
  localparam int DL_BIT = DATA_W - 3;

  logic [DATA_W-1:0] word_q;
  logic rdy_q, ovf_q, dl_q;

  wire load    = dbg_wr & dbg_valid;
  wire ovf_clr = hnd_ctl_wr & ~hnd_ctl_wdata[OV_BIT];
  wire ovf_set = load & rdy_q & ~hnd_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      rdy_q  <= 1'b0;
      ovf_q  <= 1'b0;
      dl_q   <= 1'b0;
    end else begin
      if (load) word_q <= dbg_wdata;
      if (load) rdy_q <= 1'b1;
      else if (hnd_rd) rdy_q <= 1'b0;
      if (ovf_set) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (load & dbg_dl) dl_q <= 1'b1;
      else if (dbg_dl_clr) dl_q <= 1'b0;
    end
  end

  assign hnd_rdata = word_q;

  always_comb begin
    hnd_status = '0;
    hnd_status[RR_BIT] = rdy_q;
    hnd_status[OV_BIT] = ovf_q;
    hnd_status[DL_BIT] = dl_q;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (hnd_status == '0 && hnd_rdata == '0));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (dbg_wr && dbg_valid) |=> (hnd_status[RR_BIT] && hnd_rdata == $past(dbg_wdata)));
  a_r2_invalid_ignored: assert property (@(posedge clk) disable iff (rst)
    (!(dbg_wr && dbg_valid)) |=> $stable(hnd_rdata));
  a_r4_overflow: assert property (@(posedge clk) disable iff (rst)
    (dbg_wr && dbg_valid && hnd_status[RR_BIT] && !hnd_rd) |=> hnd_status[OV_BIT]);
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (hnd_status[OV_BIT] && !(hnd_ctl_wr && !hnd_ctl_wdata[OV_BIT])) |=> hnd_status[OV_BIT]);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (hnd_rd && !(dbg_wr && dbg_valid)) |=> !hnd_status[RR_BIT]);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (hnd_rd && !hnd_status[OV_BIT] && !(hnd_ctl_wr && hnd_ctl_wdata[OV_BIT] == 1'b0)) |=> !hnd_status[OV_BIT]);
  a_r8_dl_clear: assert property (@(posedge clk) disable iff (rst)
    (dbg_dl_clr && !(dbg_wr && dbg_valid && dbg_dl)) |=> !hnd_status[DL_BIT]);
endmodule

// File: tb/dbg_rx_mailbox_tb_top.sv
module dbg_rx_mailbox_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst;
  logic dbg_wr, dbg_valid, dbg_dl, dbg_dl_clr, hnd_rd, hnd_ctl_wr;
  logic [W-1:0] dbg_wdata, hnd_ctl_wdata, hnd_rdata, hnd_status;

  always #4 clk = ~clk;

  dbg_rx_mailbox #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .dbg_wr(dbg_wr), .dbg_valid(dbg_valid), .dbg_dl(dbg_dl),
    .dbg_wdata(dbg_wdata), .dbg_dl_clr(dbg_dl_clr), .hnd_rd(hnd_rd), .hnd_rdata(hnd_rdata),
    .hnd_ctl_wr(hnd_ctl_wr), .hnd_ctl_wdata(hnd_ctl_wdata), .hnd_status(hnd_status));

  typedef struct { logic [W-1:0] stat; logic [W-1:0] data; string req; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] m_data;
  logic m_rr, m_ov, m_d;

  task automatic push(string req);
    exp_t e;
    e.stat = {m_rr, m_ov, m_d, 29'b0};
    e.data = m_data;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic op(input bit wr, input bit vl, input bit dl, input logic [W-1:0] d,
                    input bit rd, input bit dclr, input bit cw, input logic [W-1:0] cd,
                    input string req);
    bit ld;
    @(negedge clk);
    dbg_wr = wr; dbg_valid = vl; dbg_dl = dl; dbg_wdata = d;
    hnd_rd = rd; dbg_dl_clr = dclr; hnd_ctl_wr = cw; hnd_ctl_wdata = cd;
    ld = wr && vl;
    m_ov = (m_ov && !(cw && !cd[30])) || (ld && m_rr && !rd);
    m_rr = ld ? 1'b1 : (rd ? 1'b0 : m_rr);
    m_d  = (ld && dl) ? 1'b1 : (dclr ? 1'b0 : m_d);
    if (ld) m_data = d;
    @(posedge clk);
    #1 push(req);
  endtask

  task automatic idle();
    op(0, 0, 0, '0, 0, 0, 0, '0, "idle");
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (hnd_status !== e.stat || hnd_rdata !== e.data) begin
        n_fail++;
        $display("FAIL %s: status=%h data=%h expected status=%h data=%h",
                 e.req, hnd_status, hnd_rdata, e.stat, e.data);
      end
    end
  end

  initial begin
    rst = 1'b1;
    dbg_wr = 0; dbg_valid = 0; dbg_dl = 0; dbg_wdata = '0; dbg_dl_clr = 0;
    hnd_rd = 0; hnd_ctl_wr = 0; hnd_ctl_wdata = '0;
    m_data = '0; m_rr = 0; m_ov = 0; m_d = 0;
    repeat (2) @(posedge clk);
    #1 push("R1 reset");
    @(negedge clk) rst = 1'b0;
    op(1, 0, 1, 32'hDEAD0001, 0, 0, 0, '0, "R2 invalid ignored");
    op(1, 1, 0, 32'h12345678, 0, 0, 0, '0, "R2 load");
    op(0, 0, 0, '0, 0, 0, 1, 32'h4000_0000, "R10 ctl no effect");
    op(0, 0, 0, '0, 1, 0, 0, '0, "R6 read clears");
    op(0, 0, 0, '0, 1, 0, 0, '0, "R6 read when empty");
    op(1, 1, 1, 32'hA0000001, 0, 0, 0, '0, "R3 dl set");
    op(0, 0, 0, '0, 1, 0, 0, '0, "R9 layout");
    op(1, 1, 0, 32'hA0000002, 0, 0, 0, '0, "R3 dl kept");
    op(1, 1, 1, 32'hA0000003, 1, 0, 0, '0, "R7 read and write");
    op(1, 1, 1, 32'hA0000004, 0, 0, 0, '0, "R4 overflow");
    op(1, 1, 1, 32'hA0000005, 0, 0, 0, '0, "R5 sticky write");
    op(0, 0, 0, '0, 1, 0, 0, '0, "R5 sticky read");
    op(0, 0, 0, '0, 0, 0, 1, 32'hFFFF_FFFF, "R5 bit30 high keeps");
    op(0, 0, 0, '0, 0, 0, 1, 32'hBFFF_FFFF, "R5 clear");
    op(1, 1, 0, 32'hB0000001, 0, 0, 0, '0, "R2 load again");
    op(1, 1, 0, 32'hB0000002, 0, 0, 1, 32'h0, "R5 set beats clear");
    op(0, 0, 0, '0, 0, 1, 0, '0, "R8 dl clear");
    op(1, 1, 1, 32'hC0000001, 0, 1, 1, 32'h0, "R8 set beats clear");
    op(0, 0, 0, '0, 0, 0, 1, 32'h0, "R5 clear again");
    op(0, 0, 0, '0, 1, 1, 0, '0, "R8 clear with read");
    for (int i = 0; i < 8; i++)
      op(1, 1, 1, 32'hD000_0000 + i, 1, 0, 0, '0, "R7 back to back");
    op(0, 0, 0, '0, 0, 1, 0, '0, "R8 end download");
    idle();
    op(0, 0, 0, '0, 0, 0, 0, '0, "R1 pre reset");
    @(negedge clk) rst = 1'b1;
    m_data = '0; m_rr = 0; m_ov = 0; m_d = 0;
    @(posedge clk);
    #1 push("R1 reset again");
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule